// File: doc/BRIEF.md
# Audio Sample Buffer with DMA Requests

This block sits between a register bus and a streaming audio path and holds two sample stores of 1024 entries of 16 bits each, one per direction. Samples written to the transmit data port collect in the transmit store. When the store fills up, or when its occupancy matches the free space last advertised by the sink, the collected samples are streamed out in a single burst. On the receive side, reads of the data port pop samples in arrival order. When the last sample has been taken, the store refills in one chunk from the audio source.

The block keeps two level-sensitive DMA request lines and two status flags for the register block. One flag means receive data is pending and the other means transmit space is free. The codec enable and the two DMA enable bits come in as plain inputs. Samples are always stored as 16 bits, whatever sample width the codec uses.

The transmit side uses states `TX_IDLE` and `TX_FLUSH`. `TX_IDLE` goes to `TX_FLUSH` when a flush is triggered and comes back when the last entry is accepted. The receive side uses states `RX_IDLE` and `RX_FILL`. `RX_IDLE` goes to `RX_FILL` when a pop empties the store and the source has data, and `RX_FILL` goes back to `RX_IDLE` when the chunk is complete. While codec enable is low, both machines are forced to idle.

Top module: `audbuf_top`

## Requirements
- R1: After reset, both stores are empty and both machines are idle. `tx_busy`, `snk_valid`, `src_ready`, `tx_dreq` and `rx_dreq` are low, and `rx_rdata` is 0x0000.
- R2: `rx_pending` is high when any of these holds: `src_avail` is nonzero, the receive store holds samples, or a refill is running. `rx_dreq` equals `codec_en & dma_rd_en & rx_pending`.
- R3: `tx_space` is high when no flush is running and the transmit count is below the stored sink free space. `tx_dreq` equals `codec_en & dma_wr_en & tx_space`.
- R4: A `tx_wr` pulse in `TX_IDLE` appends `tx_wdata`. If the new count equals a nonzero stored free space, a flush starts. A flush behaves as follows:
  - It streams entries 0 to n-1 on `snk_valid`/`snk_ready`.
  - `snk_data` holds steady while a beat is stalled.
  - `tx_busy` stays high until the last beat.
  - At the end, the stored free space is reduced by n and the count clears.
- R5: When the count reaches 1024, the store is flushed if the stored free space is nonzero. If the stored free space is zero, the store is discarded and no beat is sent.
- R6: A `snk_free_vld` pulse in `TX_IDLE` loads `snk_free` as the stored free space. If that value is below the count, the count is clipped to it and flushed, or cleared if the value is zero.
- R7: A free-space update wins over a write in the same cycle, and the write is dropped. Writes and free-space updates are ignored during a flush.
- R8: `rx_rdata` shows the oldest buffered sample. An `rx_rd` pulse removes it, so successive reads return the samples in the order they arrived.
- R9: A read that removes the last sample, or a read of an empty store, starts a refill if `src_avail` is nonzero. The refill does the following:
  - It loads min(`src_avail`, 1024) samples through `src_valid`/`src_ready`.
  - `src_ready` is high only during the refill.
  - Reads during the refill are ignored.
  - If `src_avail` is zero, the count simply clears.
- R10: While the receive store is empty or refilling, `rx_rdata` reads 0x0000.
- R11: With `codec_en` low, both counts clear at the next edge, a running flush or refill is abandoned, and both DMA requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| codec_en | input | 1 | Codec enable; low clears both stores |
| dma_rd_en | input | 1 | Receive DMA enable |
| dma_wr_en | input | 1 | Transmit DMA enable |
| tx_wr | input | 1 | Transmit data port write strobe |
| tx_wdata | input | 16 | Transmit sample |
| tx_busy | output | 1 | Transmit flush in progress |
| tx_space | output | 1 | Transmit store below sink free space |
| tx_dreq | output | 1 | Transmit DMA request |
| snk_free_vld | input | 1 | Sink free-space update strobe |
| snk_free | input | 16 | Sink free space in samples |
| snk_valid | output | 1 | Sink beat valid |
| snk_ready | input | 1 | Sink accepts beat |
| snk_data | output | 16 | Sink sample |
| rx_rd | input | 1 | Receive data port read strobe |
| rx_rdata | output | 16 | Oldest buffered receive sample |
| rx_pending | output | 1 | Receive data pending |
| rx_dreq | output | 1 | Receive DMA request |
| src_avail | input | 16 | Samples the source has ready |
| src_valid | input | 1 | Source beat valid |
| src_ready | output | 1 | Refill accepting source beats |
| src_data | input | 16 | Source sample |

## Verification
The bench exercises the following corner cases:
- **1024-entry boundary with zero free space.** A design that flushed here would emit beats to a sink that has no room. One that never discarded would wrap its write index over the stored samples.
- **Clipping to a smaller free space, including zero.** A design that flushed the whole store would send too many beats.
- **Last-entry pop with and without source data.** A refill sized wrongly, or one that never started, would leave `rx_pending` and the read data wrong.

Sink and source stalls check that `snk_data` holds steady and that refill order is kept. Dropping `codec_en` in the middle of a refill checks that nothing stale survives.

// File: rtl/audbuf_pkg.sv
package audbuf_pkg;

    typedef enum logic {
        TX_IDLE  = 1'b0,
        TX_FLUSH = 1'b1
    } tx_state_e;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_FILL = 1'b1
    } rx_state_e;

endpackage

// File: rtl/audbuf_tx.sv
module audbuf_tx
    import audbuf_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int DW    = 16,
    parameter int FW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          free_vld,
    input  logic [FW-1:0] free,
    input  logic          snk_ready,
    output logic          snk_valid,
    output logic [DW-1:0] snk_data,
    output logic          busy,
    output logic          space
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    tx_state_e     state;
    logic [CW-1:0] len;
    logic [CW-1:0] idx;
    logic [CW-1:0] flush_n;
    logic [FW-1:0] free_q;
    logic [DW-1:0] mem [DEPTH];
    logic [CW-1:0] nxt;
    logic          wr_take;

    assign nxt     = len + CW'(1);
    assign wr_take = enable && (state == TX_IDLE) && !free_vld && wr;

    // Sample store: written only when a write is accepted.
    always_ff @(posedge clk) begin
        if (wr_take) mem[len[AW-1:0]] <= wdata;
    end

    // State register and counters.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= TX_IDLE;
            len     <= '0;
            idx     <= '0;
            flush_n <= '0;
            free_q  <= '0;
        end else if (!enable) begin
            state <= TX_IDLE;
            len   <= '0;
            idx   <= '0;
        end else begin
            unique case (state)
                TX_IDLE: begin
                    if (free_vld) begin
                        free_q <= free;
                        if (free < FW'(len)) begin
                            if (free != '0) begin
                                len     <= CW'(free);
                                flush_n <= CW'(free);
                                state   <= TX_FLUSH;
                            end else begin
                                len <= '0;
                            end
                        end
                    end else if (wr) begin
                        if (nxt == CW'(DEPTH) || FW'(nxt) == free_q) begin
                            if (free_q != '0) begin
                                len     <= nxt;
                                flush_n <= nxt;
                                state   <= TX_FLUSH;
                            end else begin
                                len <= '0;
                            end
                        end else begin
                            len <= nxt;
                        end
                    end
                end
                TX_FLUSH: begin
                    if (snk_ready) begin
                        if (idx == flush_n - CW'(1)) begin
                            idx    <= '0;
                            len    <= '0;
                            free_q <= free_q - FW'(flush_n);
                            state  <= TX_IDLE;
                        end else begin
                            idx <= idx + CW'(1);
                        end
                    end
                end
            endcase
        end
    end

    // Outputs.
    always_comb begin
        busy      = (state == TX_FLUSH);
        snk_valid = busy;
        snk_data  = busy ? mem[idx[AW-1:0]] : '0;
        space     = !busy && (FW'(len) < free_q);
    end

endmodule

// File: rtl/audbuf_rx.sv
module audbuf_rx
    import audbuf_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int DW    = 16,
    parameter int FW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          rd,
    output logic [DW-1:0] rdata,
    input  logic [FW-1:0] avail,
    input  logic          src_valid,
    input  logic [DW-1:0] src_data,
    output logic          src_ready,
    output logic          pending
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    rx_state_e     state;
    logic [CW-1:0] len;
    logic [AW-1:0] ptr;
    logic [CW-1:0] fill_cnt;
    logic [CW-1:0] fill_tgt;
    logic [DW-1:0] mem [DEPTH];
    logic [CW-1:0] chunk;

    assign chunk = (avail > FW'(DEPTH)) ? CW'(DEPTH) : CW'(avail);

    // Sample store: written by refill beats.
    always_ff @(posedge clk) begin
        if (enable && state == RX_FILL && src_valid)
            mem[fill_cnt[AW-1:0]] <= src_data;
    end

    // State register and counters.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= RX_IDLE;
            len      <= '0;
            ptr      <= '0;
            fill_cnt <= '0;
            fill_tgt <= '0;
        end else if (!enable) begin
            state    <= RX_IDLE;
            len      <= '0;
            ptr      <= '0;
            fill_cnt <= '0;
        end else begin
            unique case (state)
                RX_IDLE: begin
                    if (rd) begin
                        if (len > CW'(1)) begin
                            len <= len - CW'(1);
                            ptr <= ptr + AW'(1);
                        end else begin
                            len <= '0;
                            ptr <= '0;
                            if (avail != '0) begin
                                fill_tgt <= chunk;
                                fill_cnt <= '0;
                                state    <= RX_FILL;
                            end
                        end
                    end
                end
                RX_FILL: begin
                    if (src_valid) begin
                        fill_cnt <= fill_cnt + CW'(1);
                        if (fill_cnt == fill_tgt - CW'(1)) begin
                            len   <= fill_tgt;
                            ptr   <= '0;
                            state <= RX_IDLE;
                        end
                    end
                end
            endcase
        end
    end

    // Outputs.
    always_comb begin
        src_ready = (state == RX_FILL);
        rdata     = (state == RX_IDLE && len != '0) ? mem[ptr] : '0;
        pending   = (avail != '0) || (len != '0) || (state == RX_FILL);
    end

endmodule

// File: rtl/audbuf_dreq.sv
module audbuf_dreq (
    input  logic codec_en,
    input  logic dma_en,
    input  logic cond,
    output logic dreq
);
    always_comb dreq = codec_en && dma_en && cond;
endmodule

// File: rtl/audbuf_top.sv
module audbuf_top #(
    parameter int DEPTH = 1024,
    parameter int DW    = 16,
    parameter int FW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          codec_en,
    input  logic          dma_rd_en,
    input  logic          dma_wr_en,
    input  logic          tx_wr,
    input  logic [DW-1:0] tx_wdata,
    output logic          tx_busy,
    output logic          tx_space,
    output logic          tx_dreq,
    input  logic          snk_free_vld,
    input  logic [FW-1:0] snk_free,
    output logic          snk_valid,
    input  logic          snk_ready,
    output logic [DW-1:0] snk_data,
    input  logic          rx_rd,
    output logic [DW-1:0] rx_rdata,
    output logic          rx_pending,
    output logic          rx_dreq,
    input  logic [FW-1:0] src_avail,
    input  logic          src_valid,
    output logic          src_ready,
    input  logic [DW-1:0] src_data
);

    audbuf_tx #(.DEPTH(DEPTH), .DW(DW), .FW(FW)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (codec_en),
        .wr        (tx_wr),
        .wdata     (tx_wdata),
        .free_vld  (snk_free_vld),
        .free      (snk_free),
        .snk_ready (snk_ready),
        .snk_valid (snk_valid),
        .snk_data  (snk_data),
        .busy      (tx_busy),
        .space     (tx_space)
    );

    audbuf_rx #(.DEPTH(DEPTH), .DW(DW), .FW(FW)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (codec_en),
        .rd        (rx_rd),
        .rdata     (rx_rdata),
        .avail     (src_avail),
        .src_valid (src_valid),
        .src_data  (src_data),
        .src_ready (src_ready),
        .pending   (rx_pending)
    );

    audbuf_dreq u_tx_dreq (
        .codec_en (codec_en),
        .dma_en   (dma_wr_en),
        .cond     (tx_space),
        .dreq     (tx_dreq)
    );

    audbuf_dreq u_rx_dreq (
        .codec_en (codec_en),
        .dma_en   (dma_rd_en),
        .cond     (rx_pending),
        .dreq     (rx_dreq)
    );

endmodule

// File: rtl/audbuf_chk.sv
module audbuf_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          codec_en,
    input logic          dma_rd_en,
    input logic          dma_wr_en,
    input logic          tx_dreq,
    input logic          rx_dreq,
    input logic          tx_busy,
    input logic          snk_valid,
    input logic          snk_ready,
    input logic [DW-1:0] snk_data,
    input logic          src_ready,
    input logic          rx_pending
);
    // R3
    wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_wr_en |-> !tx_dreq);

    // R2
    rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_rd_en |-> !rx_dreq);

    // R4
    beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !codec_en)
        (snk_valid && !snk_ready) |=> (snk_valid && $stable(snk_data)));

    // R3
    busy_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |-> !tx_dreq);

    // R11
    off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !codec_en |=> (!snk_valid && !src_ready));

    // R9
    fill_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready |-> rx_pending);

endmodule

bind audbuf_top audbuf_chk #(.DW(DW)) u_chk (.*);

// File: tb/audbuf_top_tb.sv
module audbuf_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic codec_en = 1'b0, dma_rd_en = 1'b0, dma_wr_en = 1'b0;
    logic tx_wr = 1'b0;
    logic [15:0] tx_wdata = '0;
    logic tx_busy, tx_space, tx_dreq;
    logic snk_free_vld = 1'b0;
    logic [15:0] snk_free = '0;
    logic snk_valid;
    logic snk_ready = 1'b0;
    logic [15:0] snk_data;
    logic rx_rd = 1'b0;
    logic [15:0] rx_rdata;
    logic rx_pending, rx_dreq;
    logic [15:0] src_avail = '0;
    logic src_valid = 1'b0;
    logic src_ready;
    logic [15:0] src_data = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    audbuf_top u_dut (.*);

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model
    logic [15:0] tq[$];
    logic [15:0] rq[$];
    int  m_free = 0, m_fn = 0, m_tgt = 0;
    bit  m_flush = 0, m_fill = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            tq.delete(); rq.delete(); m_free = 0; m_flush = 0; m_fill = 0;
        end else if (!codec_en) begin
            tq.delete(); rq.delete(); m_flush = 0; m_fill = 0;
        end else begin
            if (m_flush) begin
                if (snk_ready) begin
                    void'(tq.pop_front());
                    if (tq.size() == 0) begin m_free -= m_fn; m_flush = 0; end
                end
            end else if (snk_free_vld) begin
                m_free = int'(snk_free);
                if (int'(snk_free) < tq.size()) begin
                    if (snk_free != 0) begin
                        while (tq.size() > int'(snk_free)) void'(tq.pop_back());
                        m_fn = int'(snk_free); m_flush = 1;
                    end else tq.delete();
                end
            end else if (tx_wr) begin
                tq.push_back(tx_wdata);
                if (tq.size() == DEPTH || tq.size() == m_free) begin
                    if (m_free != 0) begin m_fn = tq.size(); m_flush = 1; end
                    else tq.delete();
                end
            end
            if (m_fill) begin
                if (src_valid) begin
                    rq.push_back(src_data);
                    if (rq.size() == m_tgt) m_fill = 0;
                end
            end else if (rx_rd) begin
                if (rq.size() > 1) void'(rq.pop_front());
                else begin
                    rq.delete();
                    if (src_avail != 0) begin
                        m_fill = 1;
                        m_tgt = (int'(src_avail) > DEPTH) ? DEPTH : int'(src_avail);
                    end
                end
            end
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            bit e_space, e_pend;
            e_space = !m_flush && (tq.size() < m_free);
            e_pend  = (src_avail != 0) || (rq.size() != 0) || m_fill;
            chk("R4 tx_busy", int'(tx_busy), int'(m_flush));
            chk("R4 snk_valid", int'(snk_valid), int'(m_flush));
            if (m_flush) chk("R4 snk_data", int'(snk_data), int'(tq[0]));
            chk("R3 tx_space", int'(tx_space), int'(e_space));
            chk("R3 tx_dreq", int'(tx_dreq), int'(codec_en && dma_wr_en && e_space));
            chk("R9 src_ready", int'(src_ready), int'(m_fill));
            if (!m_fill && rq.size() != 0) chk("R8 rx_rdata", int'(rx_rdata), int'(rq[0]));
            else chk("R10 rx_rdata", int'(rx_rdata), 0);
            chk("R2 rx_pending", int'(rx_pending), int'(e_pend));
            chk("R2 rx_dreq", int'(rx_dreq), int'(codec_en && dma_rd_en && e_pend));
        end
    end

    // Source and sink models
    int s_avail = 0, s_idx = 0, cyc = 0, beats = 0;
    always @(posedge clk) begin
        if (rst_n && src_valid && src_ready) begin s_avail--; s_idx++; end
        if (rst_n && snk_valid && snk_ready) beats++;
        #1;
        src_avail = 16'(s_avail);
        src_valid = (s_avail > 0) && (cyc % 3 != 0);
        src_data  = 16'(s_idx * 7 + 3);
        snk_ready = (cyc % 4 != 1);
        cyc++;
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic twrite(logic [15:0] d);
        tx_wr = 1'b1; tx_wdata = d; step(); tx_wr = 1'b0;
    endtask

    task automatic fupd(int v);
        snk_free_vld = 1'b1; snk_free = 16'(v); step(); snk_free_vld = 1'b0;
    endtask

    task automatic rread();
        rx_rd = 1'b1; step(); rx_rd = 1'b0;
    endtask

    task automatic settle();
        step(); step();
        while (tx_busy || src_ready) step();
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk("R1 snk_valid", int'(snk_valid), 0);
        chk("R1 tx_dreq", int'(tx_dreq), 0);
        chk("R1 rx_dreq", int'(rx_dreq), 0);
        chk("R1 rx_rdata", int'(rx_rdata), 0);
        rst_n = 1'b1; codec_en = 1'b1; dma_rd_en = 1'b1; dma_wr_en = 1'b1;
        step();
        // R4: flush when count meets free space
        fupd(8);
        for (int i = 0; i < 5; i++) twrite(16'(16'h100 + i));
        chk("R3 space with 5 of 8", int'(tx_dreq), 1);
        for (int i = 5; i < 8; i++) twrite(16'(16'h100 + i));
        twrite(16'hdead);  // during flush: ignored (R7)
        settle();
        chk("R4 beats after first flush", beats, 8);
        chk("R4 free consumed", int'(tx_space), 0);
        // R5: zero free space, 1024 writes discarded
        for (int i = 0; i < DEPTH; i++) twrite(16'(i));
        settle();
        chk("R5 discard sends no beats", beats, 8);
        // R5: flush at 1024
        fupd(2000);
        for (int i = 0; i < DEPTH; i++) twrite(16'(i ^ 16'h5a5a));
        settle();
        chk("R5 full flush beats", beats, 8 + DEPTH);
        // R6: clip to smaller free space
        for (int i = 0; i < 10; i++) twrite(16'(16'h2000 + i));
        fupd(4);
        settle();
        chk("R6 clipped flush beats", beats, 12 + DEPTH);
        for (int i = 0; i < 3; i++) twrite(16'(16'h3000 + i));
        fupd(0);
        step();
        chk("R6 zero free discards", beats, 12 + DEPTH);
        // R7: simultaneous update and write
        snk_free_vld = 1'b1; snk_free = 16'd50; tx_wr = 1'b1; tx_wdata = 16'hbeef;
        step();
        snk_free_vld = 1'b0; tx_wr = 1'b0;
        chk("R7 write dropped keeps space", int'(tx_space), 1);
        dma_wr_en = 1'b0; step();
        chk("R3 gated tx_dreq", int'(tx_dreq), 0);
        dma_wr_en = 1'b1;
        // R10: empty read
        rread();
        chk("R10 empty read", int'(rx_rdata), 0);
        // R9: refill on empty read, then drain
        s_avail = 5; step(); step();
        rread();
        settle();
        for (int i = 0; i < 5; i++) rread();
        settle();
        chk("R9 drained no pending", int'(rx_pending), 0);
        // R9: chunk of 1024 then remainder
        s_avail = 1100; step(); step();
        rread();
        settle();
        for (int i = 0; i < DEPTH; i++) rread();
        settle();
        chk("R9 refill remainder pending", int'(rx_pending), 1);
        for (int i = 0; i < 76; i++) rread();
        step();
        chk("R9 all drained", int'(rx_pending), 0);
        // R11: disable mid-refill and with buffered transmit data
        for (int i = 0; i < 3; i++) twrite(16'(16'h4000 + i));
        s_avail = 40; step(); step();
        rread();
        repeat (10) step();
        codec_en = 1'b0; step();
        chk("R11 tx_dreq low", int'(tx_dreq), 0);
        chk("R11 rx_dreq low", int'(rx_dreq), 0);
        chk("R11 refill abandoned", int'(src_ready), 0);
        codec_en = 1'b1; step();
        chk("R11 rx store cleared", int'(rx_rdata), 0);
        chk("R11 tx count cleared", int'(tx_space), 1);
        repeat (20) step();
        finish_run();
    end
endmodule